// File: doc/BRIEF.md
# Multiplierless Carry-Save FIR Filter

This block is a fixed-coefficient finite impulse response filter built without multipliers. Each coefficient is a signed combination of two powers of two, so every tap product is just two shifted copies of the input sample, each added or subtracted. The filter has a transposed structure. Every accepted sample goes to all taps at once. Each tap folds its two shifted terms into the running partial result that arrives from its upstream neighbour.

The partial result moves between taps in redundant carry-save form: one sum vector and one carry vector, both registered at every tap. No tap has a carry chain, so the critical path is two full-adder levels deep whatever the accumulator width. A single carry-propagate adder at the tail turns the redundant pair into a two's-complement result and registers it.

Samples enter with a valid strobe and may arrive on every cycle or with gaps. The filtered output carries its own valid strobe. That strobe stays low until the delay line holds a full window of samples taken since reset.

Top module: `csfir_top`

## Requirements
- R1: Tap k has coefficient c_k = sa_k·2^a_k + sb_k·2^b_k, with signs and exponents set by parameters. The default eleven coefficients, tap 0 first, are 1, -3, 6, 20, 24, 48, 24, 20, 6, -3, 1. After a full window of zeros, a single unit sample followed by zeros gives these values in order on out_data.
- R2: For the n-th accepted sample, out_data equals the sum over k of c_k·x[n-k], reduced to 22-bit signed two's complement. x is the sequence of accepted samples since reset, and samples before reset count as zero.
- R3: The result for a sample accepted on the rising edge where in_valid is high appears, with out_valid high, exactly two rising edges later. out_valid is low after the first of those two edges.
- R4: out_valid is high only for results of the NTAPS-th and later samples accepted since reset, with NTAPS = 11 by default.
- R5: A cycle with in_valid low is ignored. in_data is not sampled, the filter history does not move, and out_data holds its value whenever out_valid is low.
- R6: While rst_n is low, out_valid and out_data are zero. The history and the fill count are cleared.
- R7: Full-scale inputs (-512 and +511 held for a whole window) give exact results with no overflow in the 22-bit path.
- R8: Samples accepted on consecutive cycles give the same results as the same samples with idle cycles between them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | High when in_data holds a new sample |
| in_data | input | 10 | Signed input sample |
| out_valid | output | 1 | High for one cycle per new filtered result |
| out_data | output | 22 | Signed filtered result |

## Verification
Two things can happen on the same edge. The carry-propagate stage loads the result of the previous sample, and the tap row accepts the next sample and overwrites the carry-save pair that the adder has just read. Back-to-back bursts force this collision on every edge. Streams with idle gaps, and a directed single-sample latency probe, separate the two events. In every case each result is compared with a behavioural convolution over the same integer coefficients, and out_valid must not assert when no result is owed.

// File: rtl/csfir_pkg.sv
package csfir_pkg;
  // default geometry of the filter
  localparam int CSF_TAPS = 11;
  localparam int CSF_DW   = 10;
  localparam int CSF_AW   = 22;
  localparam int CSF_EXPW = 5;
endpackage

// File: rtl/csfir_csa.sv
module csfir_csa #(
  parameter int W = 22
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [W-1:0] c,
  output logic [W-1:0] s,
  output logic [W-1:0] cy
);
  always_comb begin
    s  = a ^ b ^ c;
    cy = (a & b) | (a & c) | (b & c);
  end

  logic [W-1:0] in_total;
  logic [W-1:0] out_total;
  always_comb begin
    in_total  = a + b + c;
    out_total = s + (cy << 1);
  end

  // R2
  always_comb begin
    csa_sum_chk: assert (in_total == out_total);
  end
endmodule

// File: rtl/csfir_tap.sv
module csfir_tap #(
  parameter int DW    = 10,
  parameter int AW    = 22,
  parameter int SH_A  = 0,
  parameter int SH_B  = 0,
  parameter bit NEG_A = 1'b0,
  parameter bit NEG_B = 1'b0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [DW-1:0] x,
  input  logic [AW-1:0] s_in,
  input  logic [AW-1:0] c_in,
  output logic [AW-1:0] s_q,
  output logic [AW-1:0] c_q
);
  localparam int GUARD = AW - DW;

  logic [AW-1:0] x_ext;
  logic [AW-1:0] term_a;
  logic [AW-1:0] term_b;
  logic [AW-1:0] s1, c1, c1_sh;
  logic [AW-1:0] s2, c2;
  logic [AW-1:0] s_d, c_d;

  // shifted terms; a negated term is inverted here and completed by a +1
  // dropped into the empty LSB of a shifted carry vector
  always_comb begin
    x_ext  = {{GUARD{x[DW-1]}}, x};
    term_a = x_ext << SH_A;
    term_b = x_ext << SH_B;
    if (NEG_A) term_a = ~term_a;
    if (NEG_B) term_b = ~term_b;
  end

  csfir_csa #(.W(AW)) row1 (
    .a (term_a), .b (term_b), .c (s_in), .s (s1), .cy (c1)
  );

  always_comb c1_sh = (c1 << 1) | AW'(NEG_A);

  csfir_csa #(.W(AW)) row2 (
    .a (s1), .b (c1_sh), .c (c_in), .s (s2), .cy (c2)
  );

  always_comb begin
    s_d = s_q;
    c_d = c_q;
    if (en) begin
      s_d = s2;
      c_d = (c2 << 1) | AW'(NEG_B);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_q <= '0;
      c_q <= '0;
    end else begin
      s_q <= s_d;
      c_q <= c_d;
    end
  end

  // R5
  tap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> ($stable(s_q) && $stable(c_q)));
endmodule

// File: rtl/csfir_out.sv
module csfir_out #(
  parameter int AW    = 22,
  parameter int NTAPS = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [AW-1:0] s_in,
  input  logic [AW-1:0] c_in,
  output logic          out_valid,
  output logic [AW-1:0] out_data
);
  localparam int CW = (NTAPS > 1) ? $clog2(NTAPS) : 1;
  localparam logic [CW-1:0] FULL = CW'(NTAPS - 1);

  logic [CW-1:0] fill_q, fill_d;
  logic          pend_q, pend_d;
  logic          ov_d;
  logic [AW-1:0] od_d;

  always_comb begin
    fill_d = fill_q;
    pend_d = 1'b0;
    if (in_valid) begin
      if (fill_q != FULL) fill_d = fill_q + 1'b1;
      pend_d = (fill_q == FULL);
    end
    ov_d = pend_q;
    od_d = out_data;
    if (pend_q) od_d = s_in + c_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fill_q    <= '0;
      pend_q    <= 1'b0;
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      fill_q    <= fill_d;
      pend_q    <= pend_d;
      out_valid <= ov_d;
      out_data  <= od_d;
    end
  end

  // R3
  out_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid, 2));

  // R5
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(out_data) |-> out_valid);

  // R4
  out_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(fill_q == FULL, 2));
endmodule

// File: rtl/csfir_top.sv
module csfir_top
  import csfir_pkg::*;
#(
  parameter int NTAPS = CSF_TAPS,
  parameter int DW    = CSF_DW,
  parameter int AW    = CSF_AW,
  parameter int EXPW  = CSF_EXPW,
  // per-tap exponents, tap 0 in the lowest slice
  parameter logic [NTAPS-1:0][EXPW-1:0] EXP_A =
    {5'd1, 5'd1, 5'd3, 5'd4, 5'd5, 5'd6, 5'd5, 5'd4, 5'd3, 5'd1, 5'd1},
  parameter logic [NTAPS-1:0][EXPW-1:0] EXP_B =
    {5'd0, 5'd0, 5'd1, 5'd2, 5'd3, 5'd4, 5'd3, 5'd2, 5'd1, 5'd0, 5'd0},
  parameter logic [NTAPS-1:0] NEG_A = 11'b01000000010,
  parameter logic [NTAPS-1:0] NEG_B = 11'b11101110111
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic signed [DW-1:0] in_data,
  output logic                 out_valid,
  output logic signed [AW-1:0] out_data
);
  logic [AW-1:0] s_bus [NTAPS+1];
  logic [AW-1:0] c_bus [NTAPS+1];
  logic [AW-1:0] out_raw;

  assign s_bus[NTAPS] = '0;
  assign c_bus[NTAPS] = '0;

  generate
    for (genvar k = 0; k < NTAPS; k++) begin : g_tap
      csfir_tap #(
        .DW    (DW),
        .AW    (AW),
        .SH_A  (int'(EXP_A[k])),
        .SH_B  (int'(EXP_B[k])),
        .NEG_A (NEG_A[k]),
        .NEG_B (NEG_B[k])
      ) u_tap (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (in_valid),
        .x     (in_data),
        .s_in  (s_bus[k+1]),
        .c_in  (c_bus[k+1]),
        .s_q   (s_bus[k]),
        .c_q   (c_bus[k])
      );
    end
  endgenerate

  csfir_out #(.AW(AW), .NTAPS(NTAPS)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .s_in      (s_bus[0]),
    .c_in      (c_bus[0]),
    .out_valid (out_valid),
    .out_data  (out_raw)
  );

  assign out_data = out_raw;
endmodule

// File: tb/csfir_top_test.sv
`timescale 1ns/1ps
module csfir_top_test;
  localparam int NT = 11;
  localparam int COEF [NT] = '{1, -3, 6, 20, 24, 48, 24, 20, 6, -3, 1};
  localparam int NV = 24;
  localparam int STIM [NV] = '{
    3, -7, 100, 255, -256, 0, 17, -1, 511, -512, 42, -42,
    9, 300, -300, 1, -2, 77, -128, 127, 64, -65, 5, 200};

  logic              clk = 1'b0;
  logic              rst_n;
  logic              in_valid;
  logic signed [9:0] in_data;
  logic              out_valid;
  logic signed [21:0] out_data;

  csfir_top uut (
    .clk (clk), .rst_n (rst_n), .in_valid (in_valid), .in_data (in_data),
    .out_valid (out_valid), .out_data (out_data)
  );

  always #2 clk = ~clk;

  int checks = 0;
  int errors = 0;
  string cur_req = "R6";

  int hist [NT];
  int acc_cnt = 0;
  logic signed [21:0] exp_mem [0:1023];
  int wr = 0;
  int rd = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic model_reset();
    for (int k = 0; k < NT; k++) hist[k] = 0;
    acc_cnt = 0;
    rd = wr;
  endtask

  task automatic model_accept(input int x);
    longint acc;
    logic [63:0] accv;
    for (int k = NT-1; k > 0; k--) hist[k] = hist[k-1];
    hist[0] = x;
    acc = 0;
    for (int k = 0; k < NT; k++) acc += longint'(COEF[k]) * hist[k];
    accv = acc;
    acc_cnt++;
    if (acc_cnt >= NT) begin
      exp_mem[wr % 1024] = accv[21:0];
      wr++;
    end
  endtask

  task automatic push(input int x);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = 10'(x);
    model_accept(x);
  endtask

  task automatic idle(input int junk);
    @(negedge clk);
    in_valid = 1'b0;
    in_data  = 10'(junk);
  endtask

  // result monitor: every valid output is compared with the model
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (rd < wr) begin
        chk(out_data == exp_mem[rd % 1024], cur_req, out_data, exp_mem[rd % 1024]);
        rd++;
      end else begin
        chk(1'b0, {cur_req, " unexpected out_valid"}, 1, 0);
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic signed [21:0] held;
    rst_n = 1'b0; in_valid = 1'b0; in_data = '0;
    model_reset();
    repeat (3) @(negedge clk);
    // R6: outputs cleared in reset
    chk(out_valid == 1'b0, "R6 valid in reset", out_valid, 0);
    chk(out_data == 0, "R6 data in reset", out_data, 0);
    rst_n = 1'b1;

    // R4: no output during the first NT-1 samples
    cur_req = "R4";
    for (int i = 0; i < NT-1; i++) begin
      push(0);
      chk(out_valid == 1'b0, "R4 fill", out_valid, 0);
    end
    // R1: impulse response equals coefficient list
    cur_req = "R1";
    push(1);
    for (int i = 0; i < NT+2; i++) push(0);
    idle(0); idle(0); idle(0);
    chk(rd == wr, "R1 impulse results seen", rd, wr);

    // R2 / R5: table walk with an idle gap after every third sample
    cur_req = "R2";
    for (int i = 0; i < NV; i++) begin
      push(STIM[i]);
      if (i % 3 == 2) idle(-200 + i);
    end
    idle(0); idle(0); idle(0);
    chk(rd == wr, "R2 table results seen", rd, wr);

    // R5: garbage with in_valid low is ignored, output holds
    cur_req = "R5";
    held = out_data;
    for (int i = 0; i < 4; i++) begin
      idle(511 - 97 * i);
      chk(out_valid == 1'b0, "R5 no valid in idle", out_valid, 0);
      chk(out_data == held, "R5 output held", out_data, held);
    end
    push(13);
    idle(0); idle(0); idle(0);
    chk(rd == wr, "R5 result after garbage", rd, wr);

    // R3: exact two-edge latency of a lone sample
    cur_req = "R3";
    push(-50);
    idle(0);
    chk(out_valid == 1'b0, "R3 not after one edge", out_valid, 0);
    idle(0);
    chk(out_valid == 1'b1, "R3 valid after two edges", out_valid, 1);
    idle(0);
    chk(out_valid == 1'b0, "R3 single pulse", out_valid, 0);

    // R8: back-to-back burst, accept and emit on the same edges
    cur_req = "R8";
    for (int i = 0; i < NV; i++) push(STIM[NV-1-i]);
    idle(0); idle(0); idle(0);
    chk(rd == wr, "R8 burst results seen", rd, wr);

    // R7: full-scale windows
    cur_req = "R7";
    for (int i = 0; i < NT+1; i++) push(-512);
    for (int i = 0; i < NT+1; i++) push(511);
    for (int i = 0; i < NT; i++) push((i % 2 == 0) ? 511 : -512);
    idle(0); idle(0); idle(0);
    chk(rd == wr, "R7 results seen", rd, wr);

    // R6: mid-stream reset clears history and fill
    cur_req = "R6";
    rst_n = 1'b0;
    #1;
    chk(out_valid == 1'b0, "R6 valid after reset", out_valid, 0);
    chk(out_data == 0, "R6 data after reset", out_data, 0);
    model_reset();
    idle(0);
    rst_n = 1'b1;
    for (int i = 0; i < NT-1; i++) begin
      push(400 - 37 * i);
      chk(out_valid == 1'b0, "R6 refill", out_valid, 0);
    end
    for (int i = 0; i < 6; i++) push(-3 * i);
    idle(0); idle(0); idle(0);
    chk(rd == wr, "R6 results after reset", rd, wr);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule